// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs single bus transactions for a processor core whose external bus time-shares its low address byte with data and its top four address bits with status. The core presents a request with a cycle kind (memory read, memory write, I/O read, I/O write or interrupt acknowledge), a 20-bit address, write data, a two-bit segment code and the interrupt-enable flag. The sequencer walks the bus through its states, drives the address, strobes and transceiver controls, inserts wait states while the addressed device holds READY low, captures read data and hands it back with a one-clock done pulse.

The states are ST_IDLE (no cycle), ST_ADDR (T1: address out, ALE high), ST_TURN (T2: bus turnaround, strobes go active), ST_XFER (T3: data phase, READY sampled), ST_WAIT (TW: extra data-phase state while READY is low) and ST_DONE (T4: strobes released, done pulse). The transitions are: IDLE to ADDR on an accepted request; ADDR to TURN and TURN to XFER unconditionally; XFER and WAIT to DONE when READY is high, otherwise to WAIT; DONE to ADDR on an accepted request, otherwise to IDLE. A synchronous reset forces ST_IDLE from any state.

Top module: `mux_bus_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it, the block is idle: ALE low, all three strobes (rd_n, wr_n, inta_n) high, den_n high, dt_r high, io_m low, done low, and ad_oe, ah_oe, as_oe all low.
- R2: req_take is high exactly when req_valid is high and the sequencer is in ST_IDLE or ST_DONE; a req_valid in any other state is ignored and does not disturb the cycle in progress.
- R3: In ST_ADDR, ALE is high, ah_out carries address bits 15:8 and as_out carries bits 19:16 for memory cycles and 0000 for I/O and acknowledge cycles (req_kind 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 interrupt acknowledge; codes 5 to 7 act as memory read); ad_out carries bits 7:0 except in acknowledge cycles.
- R4: In ST_TURN, ST_XFER, ST_WAIT and ST_DONE, as_out carries the status {0, ie, seg[1:0]} with as_out[2] the interrupt-enable flag and as_out[1:0] the segment code (00 extra, 01 stack, 10 code or none, 11 data).
- R5: The strobe matching the cycle kind (rd_n for reads, wr_n for writes, inta_n for acknowledge) is low in ST_TURN, ST_XFER and ST_WAIT and high in every other state; at most one strobe is low.
- R6: For reads and acknowledge cycles ad_oe is low from ST_TURN through ST_DONE; for writes ad_out carries the write data with ad_oe high from ST_TURN through ST_DONE. In acknowledge cycles ad_oe and ah_oe stay low in all states.
- R7: READY low at the end of ST_XFER or ST_WAIT inserts one more ST_WAIT; READY high there moves to ST_DONE, so a cycle lasts 4 + N clocks for N low samples.
- R8: rdata takes the ad_in value present at the edge that ends ST_XFER or the last ST_WAIT of a read or acknowledge cycle, is valid in ST_DONE together with a one-clock done pulse, and holds until the next read.
- R9: io_m is high from ST_ADDR through ST_DONE of I/O cycles and low otherwise; dt_r is low from ST_ADDR through ST_DONE of read and acknowledge cycles and high otherwise.
- R10: den_n is low in ST_TURN, ST_XFER and ST_WAIT of every cycle and also in ST_DONE of write cycles, and high otherwise.
- R11: After ST_DONE with no request, the sequencer idles with ALE low, strobes high and all bus enables low until the next request.
- R12: Reset asserted in the middle of a cycle returns the sequencer to idle at the next clock edge with every strobe released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core has a request pending |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 8 | Write data |
| req_seg | input | 2 | Segment code for status |
| req_ie | input | 1 | Interrupt-enable flag for status |
| req_take | output | 1 | Request accepted this clock |
| done | output | 1 | One-clock pulse in the final state |
| rdata | output | 8 | Captured read data |
| ad_out | output | 8 | Low address / write data byte |
| ad_in | input | 8 | Low byte read back from the bus |
| ad_oe | output | 1 | Drive enable for the low byte |
| ah_out | output | 8 | Address bits 15:8 |
| ah_oe | output | 1 | Drive enable for bits 15:8 |
| as_out | output | 4 | Address bits 19:16 or status |
| as_oe | output | 1 | Drive enable for the top four lines |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Acknowledge strobe, active low |
| io_m | output | 1 | High for I/O space |
| dt_r | output | 1 | Transceiver direction, high to transmit |
| den_n | output | 1 | Transceiver enable, active low |
| ready | input | 1 | Device ready, sampled in T3 and TW |

## Verification
A wrong state shows at the pins within the same clock it is entered, because every bus output is decoded from the state register and the latched request: an extra or missing wait state moves the rise of the strobe or the done pulse by one clock, and a wrong latch shows as a wrong address or status on the first state after it. A misplaced read-data capture stays hidden until ST_DONE, where rdata is compared against the byte the bench placed on ad_in only at the final sampling edge. A request accepted in the wrong state is visible in the same clock on req_take and one clock later as a second ALE pulse.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_TURN,
        ST_XFER,
        ST_WAIT,
        ST_DONE
    } bstate_t;

    localparam int KIND_W = 3;

    localparam logic [KIND_W-1:0] K_MEM_RD = 3'd0;
    localparam logic [KIND_W-1:0] K_MEM_WR = 3'd1;
    localparam logic [KIND_W-1:0] K_IO_RD  = 3'd2;
    localparam logic [KIND_W-1:0] K_IO_WR  = 3'd3;
    localparam logic [KIND_W-1:0] K_ACK    = 3'd4;

    typedef struct packed {
        logic is_io;
        logic is_wr;
        logic is_ack;
    } kflags_t;

    function automatic kflags_t kind_flags(input logic [KIND_W-1:0] k);
        kflags_t f;
        f = '0;
        case (k)
            K_MEM_WR: f.is_wr  = 1'b1;
            K_IO_RD:  f.is_io  = 1'b1;
            K_IO_WR:  begin f.is_io = 1'b1; f.is_wr = 1'b1; end
            K_ACK:    f.is_ack = 1'b1;
            default:  f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
    import busseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    ready,
    output bstate_t st,
    output logic    take
);

    bstate_t nxt;

    always_comb begin
        take = req_valid && (st == ST_IDLE || st == ST_DONE);
        nxt  = ST_IDLE;
        unique case (st)
            ST_IDLE: nxt = take ? ST_ADDR : ST_IDLE;
            ST_ADDR: nxt = ST_TURN;
            ST_TURN: nxt = ST_XFER;
            ST_XFER: nxt = ready ? ST_DONE : ST_WAIT;
            ST_WAIT: nxt = ready ? ST_DONE : ST_WAIT;
            ST_DONE: nxt = take ? ST_ADDR : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= nxt;
    end

endmodule

// File: rtl/busseq_hold.sv
module busseq_hold
    import busseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int SEG_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic              req_ie,
    input  bstate_t           st,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output kflags_t           fl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [SEG_W-1:0]  seg_q,
    output logic              ie_q,
    output logic [DATA_W-1:0] rdata
);

    logic last_data;
    assign last_data = (st == ST_XFER || st == ST_WAIT) && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            seg_q   <= '0;
            ie_q    <= 1'b0;
        end else if (take) begin
            fl_q    <= kind_flags(req_kind);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            seg_q   <= req_seg;
            ie_q    <= req_ie;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         rdata <= '0;
        else if (last_data && !fl_q.is_wr) rdata <= ad_in;
    end

endmodule

// File: rtl/busseq_pins.sv
module busseq_pins
    import busseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int MID_W  = 8,
    parameter int SEG_W  = 2
) (
    input  bstate_t           st,
    input  kflags_t           fl_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic [SEG_W-1:0]  seg_q,
    input  logic              ie_q,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [MID_W-1:0]  ah_out,
    output logic              ah_oe,
    output logic [ADDR_W-DATA_W-MID_W-1:0] as_out,
    output logic              as_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              io_m,
    output logic              dt_r,
    output logic              den_n,
    output logic              done
);

    localparam int TOP_W = ADDR_W - DATA_W - MID_W;
    localparam int PAD_W = TOP_W - SEG_W - 1;

    logic                   strobe;
    logic                   rd_kind;
    logic [TOP_W-1:0]       status;
    logic [TOP_W-1:0]       top_addr;

    assign rd_kind  = !fl_q.is_wr && !fl_q.is_ack;
    assign status   = {{PAD_W{1'b0}}, ie_q, seg_q};
    assign top_addr = (fl_q.is_io || fl_q.is_ack) ? '0 : addr_q[ADDR_W-1 -: TOP_W];

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        ah_out = addr_q[DATA_W +: MID_W];
        ah_oe  = 1'b0;
        as_out = status;
        as_oe  = 1'b0;
        ale    = 1'b0;
        strobe = 1'b0;
        io_m   = 1'b0;
        dt_r   = 1'b1;
        den_n  = 1'b1;
        done   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                ah_out = '0;
                as_out = '0;
            end
            ST_ADDR: begin
                ale    = 1'b1;
                ad_out = addr_q[DATA_W-1:0];
                ad_oe  = !fl_q.is_ack;
                ah_oe  = !fl_q.is_ack;
                as_out = top_addr;
                as_oe  = 1'b1;
                io_m   = fl_q.is_io;
                dt_r   = fl_q.is_wr;
            end
            ST_TURN, ST_XFER, ST_WAIT: begin
                strobe = 1'b1;
                ad_out = wdata_q;
                ad_oe  = fl_q.is_wr;
                ah_oe  = !fl_q.is_ack;
                as_oe  = 1'b1;
                io_m   = fl_q.is_io;
                dt_r   = fl_q.is_wr;
                den_n  = 1'b0;
            end
            ST_DONE: begin
                ad_out = wdata_q;
                ad_oe  = fl_q.is_wr;
                ah_oe  = !fl_q.is_ack;
                as_oe  = 1'b1;
                io_m   = fl_q.is_io;
                dt_r   = fl_q.is_wr;
                den_n  = !fl_q.is_wr;
                done   = 1'b1;
            end
            default: begin
                ah_out = '0;
                as_out = '0;
            end
        endcase
        rd_n   = !(strobe && rd_kind);
        wr_n   = !(strobe && fl_q.is_wr);
        inta_n = !(strobe && fl_q.is_ack);
    end

endmodule

// File: rtl/mux_bus_sequencer.sv
module mux_bus_sequencer
    import busseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8,
    parameter int MID_W  = 8,
    parameter int SEG_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic              req_ie,
    output logic              req_take,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ad_out,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ad_oe,
    output logic [MID_W-1:0]  ah_out,
    output logic              ah_oe,
    output logic [ADDR_W-DATA_W-MID_W-1:0] as_out,
    output logic              as_oe,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              inta_n,
    output logic              io_m,
    output logic              dt_r,
    output logic              den_n,
    input  logic              ready
);

    bstate_t           st;
    kflags_t           fl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [SEG_W-1:0]  seg_q;
    logic              ie_q;

    busseq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .ready     (ready),
        .st        (st),
        .take      (req_take)
    );

    busseq_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .take      (req_take),
        .req_kind  (req_kind),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_seg   (req_seg),
        .req_ie    (req_ie),
        .st        (st),
        .ready     (ready),
        .ad_in     (ad_in),
        .fl_q      (fl_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .seg_q     (seg_q),
        .ie_q      (ie_q),
        .rdata     (rdata)
    );

    busseq_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MID_W(MID_W), .SEG_W(SEG_W)) u_pins (
        .st      (st),
        .fl_q    (fl_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .seg_q   (seg_q),
        .ie_q    (ie_q),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ah_out  (ah_out),
        .ah_oe   (ah_oe),
        .as_out  (as_out),
        .as_oe   (as_oe),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .inta_n  (inta_n),
        .io_m    (io_m),
        .dt_r    (dt_r),
        .den_n   (den_n),
        .done    (done)
    );

endmodule

// File: rtl/busseq_chk.sv
module busseq_chk
    import busseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input bstate_t           st,
    input logic              req_take,
    input logic              ready,
    input logic [DATA_W-1:0] ad_in,
    input logic [DATA_W-1:0] rdata,
    input logic              done,
    input logic              ale,
    input logic              rd_n,
    input logic              wr_n,
    input logic              inta_n,
    input logic              den_n
);

    // R2: no acceptance while a cycle is in flight
    a_r2_no_take_busy: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && st != ST_DONE) |-> !req_take);

    // R3: ALE is a one-clock pulse
    a_r3_ale_single: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    // R5: never two strobes at once
    a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({!rd_n, !wr_n, !inta_n}) <= 1);

    // R7: READY low in the data phase adds a wait state
    a_r7_wait_insert: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_XFER || st == ST_WAIT) && !ready) |=> (st == ST_WAIT));

    // R7: READY high in the data phase ends it
    a_r7_wait_leave: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_XFER || st == ST_WAIT) && ready) |=> (st == ST_DONE && done));

    // R8: read data is taken at the last data-phase edge
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_XFER || st == ST_WAIT) && ready && !rd_n) |=> (rdata == $past(ad_in)));

    // R10: transceiver enabled whenever a strobe is active
    a_r10_den_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n || !inta_n) |-> !den_n);

    // R12: reset leads to idle
    a_r12_reset_idle: assert property (@(posedge clk)
        rst |=> (st == ST_IDLE));

endmodule

bind mux_bus_sequencer busseq_chk #(.DATA_W(DATA_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .req_take (req_take),
    .ready    (ready),
    .ad_in    (ad_in),
    .rdata    (rdata),
    .done     (done),
    .ale      (ale),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .inta_n   (inta_n),
    .den_n    (den_n)
);

// File: tb/test_mux_bus_sequencer.sv
module test_mux_bus_sequencer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [1:0]  req_seg = '0;
    logic        req_ie = 1'b0;
    logic        req_take, done;
    logic [7:0]  rdata, ad_out, ah_out;
    logic [7:0]  ad_in = '0;
    logic        ad_oe, ah_oe, as_oe;
    logic [3:0]  as_out;
    logic        ale, rd_n, wr_n, inta_n, io_m, dt_r, den_n;
    logic        ready = 1'b1;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [7:0] last_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_bus_sequencer i_mux_bus_sequencer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_seg(req_seg),
        .req_ie(req_ie), .req_take(req_take), .done(done), .rdata(rdata),
        .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ah_out(ah_out),
        .ah_oe(ah_oe), .as_out(as_out), .as_oe(as_oe), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .io_m(io_m),
        .dt_r(dt_r), .den_n(den_n), .ready(ready)
    );

    task automatic chk(input string rq, input string nm,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, nm, act, exp, $time);
        end
    endtask

    // phase: 0 idle, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4
    task automatic check_phase(input int ph, input int kind, input logic [19:0] a,
                               input logic [7:0] wd, input logic [1:0] sg,
                               input logic ie, input string ctx);
        bit act  = (ph >= 1);
        bit strb = (ph >= 2 && ph <= 4);
        bit io   = (kind == 2 || kind == 3);
        bit wr   = (kind == 1 || kind == 3);
        bit ack  = (kind == 4);
        bit rdk  = act && !wr;
        bit e_adoe = act && ((ph == 1 && !ack) || (ph >= 2 && wr));
        string r3  = (ph == 0) ? ctx : "R3";
        string r4  = (ph == 0) ? ctx : "R4";
        string r5  = (ph == 0) ? ctx : "R5";
        string r6  = (ph == 0) ? ctx : "R6";
        string r8  = (ph == 0) ? ctx : "R8";
        string r9  = (ph == 0) ? ctx : "R9";
        string r10 = (ph == 0) ? ctx : "R10";
        chk(r3, "ale", ale, ph == 1);
        chk(r5, "rd_n", rd_n, !(strb && act && !wr && !ack));
        chk(r5, "wr_n", wr_n, !(strb && act && wr));
        chk(r5, "inta_n", inta_n, !(strb && act && ack));
        chk(r6, "ad_oe", ad_oe, e_adoe);
        if (e_adoe) chk(r6, "ad_out", ad_out, (ph == 1) ? a[7:0] : wd);
        chk(r3, "ah_oe", ah_oe, act && !ack);
        if (act && !ack) chk(r3, "ah_out", ah_out, a[15:8]);
        chk(r4, "as_oe", as_oe, act);
        if (ph == 1) chk(r3, "as_out", as_out, (io || ack) ? 4'h0 : a[19:16]);
        if (ph >= 2) chk(r4, "as_out", as_out, {1'b0, ie, sg});
        chk(r9, "io_m", io_m, act && io);
        chk(r9, "dt_r", dt_r, !rdk);
        chk(r10, "den_n", den_n, !(strb || (ph == 5 && wr)));
        chk(r8, "done", done, ph == 5);
    endtask

    // Starts at a sample point where the sequencer is in ST_IDLE or ST_DONE.
    task automatic run_cycle(input int kind, input logic [19:0] a, input logic [7:0] wd,
                             input logic [1:0] sg, input logic ie, input int waits,
                             input logic [7:0] rv, input bit poke);
        req_valid = 1'b1; req_kind = kind[2:0]; req_addr = a;
        req_wdata = wd; req_seg = sg; req_ie = ie;
        #1;
        chk("R2", "req_take", req_take, 1);
        @(posedge clk); #1;
        req_valid = 1'b0;
        check_phase(1, kind, a, wd, sg, ie, "R3");
        @(posedge clk); #1;
        check_phase(2, kind, a, wd, sg, ie, "R5");
        if (poke) begin
            req_valid = 1'b1; req_addr = ~a; req_kind = 3'd1;
            #1;
            chk("R2", "req_take_busy", req_take, 0);
            req_valid = 1'b0;
        end
        ready = (waits == 0);
        ad_in = (waits == 0) ? rv : ~rv;
        @(posedge clk); #1;
        check_phase(3, kind, a, wd, sg, ie, "R7");
        for (int k = 1; k <= waits; k++) begin
            @(posedge clk); #1;
            check_phase(4, kind, a, wd, sg, ie, "R7");
            ready = (k == waits);
            ad_in = (k == waits) ? rv : ~rv;
        end
        @(posedge clk); #1;
        check_phase(5, kind, a, wd, sg, ie, "R7");
        if (!(kind == 1 || kind == 3)) begin
            chk("R8", "rdata", rdata, rv);
            last_rd = rv;
        end
        ready = 1'b1;
    endtask

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            check_phase(0, 0, '0, '0, '0, 1'b0, "R11");
            chk("R8", "rdata_hold", rdata, last_rd);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd7319);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check_phase(0, 0, '0, '0, '0, 1'b0, "R1");
        chk("R1", "rdata", rdata, 8'h00);
        rst = 1'b0;
        @(posedge clk); #1;
        check_phase(0, 0, '0, '0, '0, 1'b0, "R1");

        // Directed: each kind, zero waits, then with waits
        run_cycle(0, 20'hA5C3E, 8'h00, 2'b10, 1'b1, 0, 8'h5A, 1'b0); idle_gap(1);
        run_cycle(1, 20'h3F012, 8'hC7, 2'b11, 1'b0, 0, 8'h00, 1'b1); idle_gap(1);
        run_cycle(2, 20'hF1234, 8'h00, 2'b01, 1'b1, 2, 8'h96, 1'b1); idle_gap(2);
        run_cycle(3, 20'h9ABCD, 8'h3C, 2'b00, 1'b1, 3, 8'h00, 1'b0); idle_gap(1);
        run_cycle(4, 20'h7E0FF, 8'h00, 2'b10, 1'b0, 1, 8'h21, 1'b0);
        // Back-to-back from ST_DONE (R2)
        run_cycle(0, 20'h00001, 8'h00, 2'b11, 1'b0, 4, 8'hE4, 1'b1);
        run_cycle(1, 20'hFFFFF, 8'hFF, 2'b01, 1'b1, 0, 8'h00, 1'b0);
        idle_gap(1);

        // Reset in the middle of a wait state (R12)
        req_valid = 1'b1; req_kind = 3'd0; req_addr = 20'h12345; #1;
        @(posedge clk); #1; req_valid = 1'b0; ready = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R12", "strobe_mid", rd_n, 0);
        rst = 1'b1;
        @(posedge clk); #1;
        check_phase(0, 0, '0, '0, '0, 1'b0, "R12");
        rst = 1'b0; ready = 1'b1; last_rd = 8'h00;
        @(posedge clk); #1;
        check_phase(0, 0, '0, '0, '0, 1'b0, "R12");

        // Random mix
        for (int n = 0; n < 60; n++) begin
            int kind  = $urandom_range(0, 4);
            int waits = $urandom_range(0, 3);
            logic [19:0] a  = 20'($urandom);
            logic [7:0]  wd = 8'($urandom);
            logic [7:0]  rv = 8'($urandom);
            logic [1:0]  sg = 2'($urandom);
            logic        ie = 1'($urandom);
            bit          pk = 1'($urandom);
            run_cycle(kind, a, wd, sg, ie, waits, rv, pk);
            if ($urandom_range(0, 2) != 0) idle_gap($urandom_range(1, 2));
        end
        idle_gap(1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule